// File: doc/BRIEF.md
# Two-wire bus controller register and interrupt block

This block is the host-facing register file of a two-wire serial bus controller. A host reads and writes five 16-bit registers through a simple synchronous port. Software-written fields go straight to the bus engines: the own slave address, the bit-rate code, the mode bits and the transmit byte. Single-cycle event pulses from the engines are gathered into sticky status flags. These flags drive one interrupt request line.

Bus start and stop requests are not separate commands. They come from changes of the master-select bit in the control register, checked against the value already stored. A repeated start is requested with a write-only control bit. A global enable bit gates every other control function. The registers stay readable and writable while it is clear. Read data appears one cycle after the read strobe, and it is zero in every other cycle.

Top module: `twi_ctl_regs`

## Requirements
- R1: After reset every register reads 0, and every output is 0.
- R2: Offset 0x00 stores a 7-bit own address in bits 7:1, and offset 0x04 stores a 6-bit rate code in bits 5:0. Every other bit reads 0. Both fields drive their outputs the cycle after the write. A read of an unmapped offset returns 0, and a write to it changes nothing.
- R3: The control register at 0x08 has these bits: 7 enable, 6 interrupt enable, 5 master select, 4 transmit mode, 3 acknowledge suppress, 2 repeated start. Bit 2 and all bits not listed read 0.
- R4: While the enable bit is 0, the outputs master_mode, tx_mode, ack_off and irq are 0, and no start, stop or repeated-start pulse is issued. The stored register values are kept and read back.
- R5: A control write with enable=1 and master select 1 pulses start_req for one cycle when the stored master bit was 0. The same write with master select 0 pulses stop_req when the stored bit was 1. Writing the same master value again gives no pulse.
- R6: A control write with enable=1 and bit 2 set pulses rstart_req for one cycle.
- R7: The status register at 0x0C has these bits, sampled at the read edge: 0 NACK seen (lv_nack), 2 slave read (lv_slave_rd), 5 bus busy (lv_bus_busy), 6 addressed (lv_addressed), 7 transfer done (lv_xfer_done). Bits 1 and 4 are the sticky flags. Bit 3 and bits 15:8 read 0.
- R8: Each pulse on ev_byte_done, ev_addr_match or ev_arb_lost sets the interrupt flag (status bit 1), even while interrupt enable is 0. A pulse on ev_arb_lost also sets the arbitration flag (status bit 4).
- R9: A status write with 0 in bit 1 or bit 4 clears that flag. A 1 in those bits has no effect. An event in the same cycle as a clearing write wins, and the flag stays set.
- R10: irq is 1 exactly when the interrupt flag, interrupt enable and enable are all 1.
- R11: A host write to 0x10 stores bits 7:0 on tx_byte and pulses tx_load for one cycle. A host read of 0x10 pulses rx_read for one cycle. rx_wr loads rx_byte into the data register. When a host write and rx_wr fall in the same cycle, the host write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 5 | Byte offset of the register |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, one cycle after host_rd, 0 otherwise |
| ev_byte_done | input | 1 | Engine pulse: byte transfer finished |
| ev_addr_match | input | 1 | Engine pulse: own address matched |
| ev_arb_lost | input | 1 | Engine pulse: arbitration lost |
| lv_nack | input | 1 | Engine level: last acknowledge was NACK |
| lv_slave_rd | input | 1 | Engine level: remote master is reading |
| lv_bus_busy | input | 1 | Engine level: bus busy |
| lv_addressed | input | 1 | Engine level: addressed as slave |
| lv_xfer_done | input | 1 | Engine level: byte transfer complete |
| rx_wr | input | 1 | Engine loads a received byte |
| rx_byte | input | 8 | Received byte |
| own_addr | output | 7 | Own slave address |
| clk_code | output | 6 | Bit-rate code |
| core_en | output | 1 | Block enable |
| ack_off | output | 1 | Suppress acknowledge, gated by enable |
| tx_mode | output | 1 | Transmit direction, gated by enable |
| master_mode | output | 1 | Master mode, gated by enable |
| start_req | output | 1 | One-cycle start request |
| stop_req | output | 1 | One-cycle stop request |
| rstart_req | output | 1 | One-cycle repeated-start request |
| tx_byte | output | 8 | Data register contents |
| tx_load | output | 1 | One-cycle pulse after a host data write |
| rx_read | output | 1 | One-cycle pulse after a host data read |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can meet in one clock cycle. In the first, a software status write that clears a sticky flag lands in the same cycle as an engine event that sets it. In the second, a host data write lands in the same cycle as an engine receive load. Directed steps force both pairs. The random phase mixes host writes and reads with event pulses of low probability, so a clear and a set also meet unplanned. A model of flags and registers in the bench decides the outcome: set over clear, and host over engine. It checks the flag through both the irq output and a later status read, and the data register through tx_byte and a data read.

// File: rtl/twi_regs_pkg.sv
package twi_regs_pkg;

    localparam int NREG     = 5;
    localparam int IDX_OWN  = 0;
    localparam int IDX_DIV  = 1;
    localparam int IDX_CTL  = 2;
    localparam int IDX_STAT = 3;
    localparam int IDX_DATA = 4;

    // control register bit positions
    localparam int CB_RSTART = 2;
    localparam int CB_NOACK  = 3;
    localparam int CB_TX     = 4;
    localparam int CB_MASTER = 5;
    localparam int CB_IRQEN  = 6;
    localparam int CB_EN     = 7;

    // status register bit positions
    localparam int SB_NACK  = 0;
    localparam int SB_IRQ   = 1;
    localparam int SB_SLVRD = 2;
    localparam int SB_ARB   = 4;
    localparam int SB_BUSY  = 5;
    localparam int SB_HIT   = 6;
    localparam int SB_DONE  = 7;

    typedef struct packed {
        logic core_en;
        logic irq_en;
        logic master;
        logic tx_mode;
        logic ack_off;
    } ctl_bits_t;

    function automatic int reg_offset(input int idx);
        return idx * 4;
    endfunction

endpackage

// File: rtl/twi_reg_decode.sv
module twi_reg_decode
    import twi_regs_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [NREG-1:0]   wr_hit,
    output logic [NREG-1:0]   rd_hit
);

    for (genvar i = 0; i < NREG; i++) begin : g_dec
        localparam logic [ADDR_W-1:0] OFF = ADDR_W'(reg_offset(i));
        logic match;
        assign match     = (host_addr == OFF);
        assign wr_hit[i] = host_wr & match;
        assign rd_hit[i] = host_rd & match;
    end

endmodule

// File: rtl/twi_ctrl_file.sv
module twi_ctrl_file
    import twi_regs_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int SADDR_W = 7,
    parameter int DIV_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREG-1:0]    wr_hit,
    input  logic               rd_data_hit,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic               rx_wr,
    input  logic [BYTE_W-1:0]  rx_byte,
    output logic [SADDR_W-1:0] own_addr,
    output logic [DIV_W-1:0]   clk_code,
    output ctl_bits_t          ctl_o,
    output logic [BYTE_W-1:0]  data_byte,
    output logic               start_req,
    output logic               stop_req,
    output logic               rstart_req,
    output logic               tx_load,
    output logic               rx_read
);

    typedef struct packed {
        logic [SADDR_W-1:0] own;
        logic [DIV_W-1:0]   div;
        ctl_bits_t          ctl;
        logic [BYTE_W-1:0]  data;
        logic               start;
        logic               stop;
        logic               rstart;
        logic               load;
        logic               rread;
    } cf_state_t;

    cf_state_t s_d, s_q;
    logic      unused_stat;
    logic      wr_en_bit;

    assign unused_stat = wr_hit[IDX_STAT];
    assign wr_en_bit   = wdata[CB_EN];

    always_comb begin
        s_d        = s_q;
        s_d.start  = 1'b0;
        s_d.stop   = 1'b0;
        s_d.rstart = 1'b0;
        s_d.load   = 1'b0;
        s_d.rread  = rd_data_hit;

        if (wr_hit[IDX_OWN]) s_d.own = wdata[SADDR_W:1];
        if (wr_hit[IDX_DIV]) s_d.div = wdata[DIV_W-1:0];

        if (wr_hit[IDX_CTL]) begin
            s_d.ctl.core_en = wr_en_bit;
            s_d.ctl.irq_en  = wdata[CB_IRQEN];
            s_d.ctl.master  = wdata[CB_MASTER];
            s_d.ctl.tx_mode = wdata[CB_TX];
            s_d.ctl.ack_off = wdata[CB_NOACK];
            // edges are judged against the stored master bit
            s_d.start  = wr_en_bit &  wdata[CB_MASTER] & ~s_q.ctl.master;
            s_d.stop   = wr_en_bit & ~wdata[CB_MASTER] &  s_q.ctl.master;
            s_d.rstart = wr_en_bit &  wdata[CB_RSTART];
        end

        if (wr_hit[IDX_DATA]) begin
            s_d.data = wdata;
            s_d.load = 1'b1;
        end else if (rx_wr) begin
            s_d.data = rx_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign own_addr   = s_q.own;
    assign clk_code   = s_q.div;
    assign ctl_o      = s_q.ctl;
    assign data_byte  = s_q.data;
    assign start_req  = s_q.start;
    assign stop_req   = s_q.stop;
    assign rstart_req = s_q.rstart;
    assign tx_load    = s_q.load;
    assign rx_read    = s_q.rread;

endmodule

// File: rtl/twi_status_sticky.sv
module twi_status_sticky
    import twi_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stat_wr,
    input  logic keep_irq,
    input  logic keep_arb,
    input  logic ev_byte_done,
    input  logic ev_addr_match,
    input  logic ev_arb_lost,
    output logic irq_flag,
    output logic arb_flag
);

    localparam int NFLAG = 2;
    localparam int F_IRQ = 0;
    localparam int F_ARB = 1;

    typedef struct packed {
        logic [NFLAG-1:0] flags;
    } st_state_t;

    st_state_t        s_d, s_q;
    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] clr_v;

    always_comb begin
        set_v[F_IRQ] = ev_byte_done | ev_addr_match | ev_arb_lost;
        set_v[F_ARB] = ev_arb_lost;
        clr_v[F_IRQ] = stat_wr & ~keep_irq;
        clr_v[F_ARB] = stat_wr & ~keep_arb;
        // set has priority over a software clear in the same cycle
        s_d.flags    = set_v | (s_q.flags & ~clr_v);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_flag = s_q.flags[F_IRQ];
    assign arb_flag = s_q.flags[F_ARB];

endmodule

// File: rtl/twi_ctl_regs.sv
module twi_ctl_regs
    import twi_regs_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 5,
    parameter int BYTE_W  = 8,
    parameter int SADDR_W = 7,
    parameter int DIV_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    input  logic               ev_byte_done,
    input  logic               ev_addr_match,
    input  logic               ev_arb_lost,
    input  logic               lv_nack,
    input  logic               lv_slave_rd,
    input  logic               lv_bus_busy,
    input  logic               lv_addressed,
    input  logic               lv_xfer_done,
    input  logic               rx_wr,
    input  logic [BYTE_W-1:0]  rx_byte,
    output logic [SADDR_W-1:0] own_addr,
    output logic [DIV_W-1:0]   clk_code,
    output logic               core_en,
    output logic               ack_off,
    output logic               tx_mode,
    output logic               master_mode,
    output logic               start_req,
    output logic               stop_req,
    output logic               rstart_req,
    output logic [BYTE_W-1:0]  tx_byte,
    output logic               tx_load,
    output logic               rx_read,
    output logic               irq
);

    logic [NREG-1:0]   wr_hit;
    logic [NREG-1:0]   rd_hit;
    ctl_bits_t         ctl;
    logic              irq_flag;
    logic              arb_flag;
    logic              unused_hi;
    logic [BYTE_W-1:0] ctl_b;
    logic [BYTE_W-1:0] stat_b;
    logic [DATA_W-1:0] words [NREG];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    assign unused_hi = ^host_wdata[DATA_W-1:BYTE_W];

    twi_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_addr (host_addr),
        .wr_hit    (wr_hit),
        .rd_hit    (rd_hit)
    );

    twi_ctrl_file #(.BYTE_W(BYTE_W), .SADDR_W(SADDR_W), .DIV_W(DIV_W)) u_cf (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_hit      (wr_hit),
        .rd_data_hit (rd_hit[IDX_DATA]),
        .wdata       (host_wdata[BYTE_W-1:0]),
        .rx_wr       (rx_wr),
        .rx_byte     (rx_byte),
        .own_addr    (own_addr),
        .clk_code    (clk_code),
        .ctl_o       (ctl),
        .data_byte   (tx_byte),
        .start_req   (start_req),
        .stop_req    (stop_req),
        .rstart_req  (rstart_req),
        .tx_load     (tx_load),
        .rx_read     (rx_read)
    );

    twi_status_sticky u_st (
        .clk           (clk),
        .rst_n         (rst_n),
        .stat_wr       (wr_hit[IDX_STAT]),
        .keep_irq      (host_wdata[SB_IRQ]),
        .keep_arb      (host_wdata[SB_ARB]),
        .ev_byte_done  (ev_byte_done),
        .ev_addr_match (ev_addr_match),
        .ev_arb_lost   (ev_arb_lost),
        .irq_flag      (irq_flag),
        .arb_flag      (arb_flag)
    );

    always_comb begin
        ctl_b            = '0;
        ctl_b[CB_EN]     = ctl.core_en;
        ctl_b[CB_IRQEN]  = ctl.irq_en;
        ctl_b[CB_MASTER] = ctl.master;
        ctl_b[CB_TX]     = ctl.tx_mode;
        ctl_b[CB_NOACK]  = ctl.ack_off;

        stat_b           = '0;
        stat_b[SB_NACK]  = lv_nack;
        stat_b[SB_IRQ]   = irq_flag;
        stat_b[SB_SLVRD] = lv_slave_rd;
        stat_b[SB_ARB]   = arb_flag;
        stat_b[SB_BUSY]  = lv_bus_busy;
        stat_b[SB_HIT]   = lv_addressed;
        stat_b[SB_DONE]  = lv_xfer_done;

        words[IDX_OWN]  = DATA_W'({own_addr, 1'b0});
        words[IDX_DIV]  = DATA_W'(clk_code);
        words[IDX_CTL]  = DATA_W'(ctl_b);
        words[IDX_STAT] = DATA_W'(stat_b);
        words[IDX_DATA] = DATA_W'(tx_byte);

        rdata_d = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_hit[i]) rdata_d = rdata_d | words[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign host_rdata  = rdata_q;
    assign core_en     = ctl.core_en;
    assign ack_off     = ctl.ack_off & ctl.core_en;
    assign tx_mode     = ctl.tx_mode & ctl.core_en;
    assign master_mode = ctl.master  & ctl.core_en;
    assign irq         = irq_flag & ctl.irq_en & ctl.core_en;

endmodule

module twi_ctl_regs_chk
    import twi_regs_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic              wdata_irq_bit,
    input logic              ev_any,
    input logic              irq_flag,
    input logic              core_en,
    input logic              master_mode,
    input logic              ack_off,
    input logic              tx_mode,
    input logic              start_req,
    input logic              stop_req,
    input logic              rstart_req,
    input logic              tx_load,
    input logic              irq
);

    localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(reg_offset(IDX_STAT));
    localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(reg_offset(IDX_DATA));

    // R4
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_en |-> !(master_mode || ack_off || tx_mode || irq || start_req || stop_req || rstart_req));

    // R5
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_req && stop_req));

    // R5
    start_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |-> master_mode);

    // R6
    rstart_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rstart_req |-> core_en);

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_any |=> irq_flag);

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_flag) |-> $past(host_wr && host_addr == OFF_STAT && !wdata_irq_bit && !ev_any));

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_flag);

    // R11
    load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> $past(host_wr && host_addr == OFF_DATA));

endmodule

bind twi_ctl_regs twi_ctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_wr       (host_wr),
    .host_addr     (host_addr),
    .wdata_irq_bit (host_wdata[1]),
    .ev_any        (ev_byte_done | ev_addr_match | ev_arb_lost),
    .irq_flag      (irq_flag),
    .core_en       (core_en),
    .master_mode   (master_mode),
    .ack_off       (ack_off),
    .tx_mode       (tx_mode),
    .start_req     (start_req),
    .stop_req      (stop_req),
    .rstart_req    (rstart_req),
    .tx_load       (tx_load),
    .irq           (irq)
);

// File: tb/sim_twi_ctl_regs.sv
module sim_twi_ctl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        ev_byte_done = 1'b0, ev_addr_match = 1'b0, ev_arb_lost = 1'b0;
    logic        lv_nack = 1'b0, lv_slave_rd = 1'b0, lv_bus_busy = 1'b0;
    logic        lv_addressed = 1'b0, lv_xfer_done = 1'b0;
    logic        rx_wr = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [6:0]  own_addr;
    logic [5:0]  clk_code;
    logic        core_en, ack_off, tx_mode, master_mode;
    logic        start_req, stop_req, rstart_req, tx_load, rx_read, irq;
    logic [7:0]  tx_byte;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model
    logic [6:0] m_own = '0;
    logic [5:0] m_div = '0;
    logic       m_en = 0, m_ie = 0, m_ms = 0, m_tx = 0, m_ak = 0;
    logic [7:0] m_data = '0;
    logic       m_irqf = 0, m_arb = 0;

    always #4 clk = ~clk;

    twi_ctl_regs u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ev_byte_done(ev_byte_done), .ev_addr_match(ev_addr_match), .ev_arb_lost(ev_arb_lost),
        .lv_nack(lv_nack), .lv_slave_rd(lv_slave_rd), .lv_bus_busy(lv_bus_busy),
        .lv_addressed(lv_addressed), .lv_xfer_done(lv_xfer_done),
        .rx_wr(rx_wr), .rx_byte(rx_byte), .own_addr(own_addr), .clk_code(clk_code),
        .core_en(core_en), .ack_off(ack_off), .tx_mode(tx_mode), .master_mode(master_mode),
        .start_req(start_req), .stop_req(stop_req), .rstart_req(rstart_req),
        .tx_byte(tx_byte), .tx_load(tx_load), .rx_read(rx_read), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] rd_val(input logic [4:0] a, input logic [4:0] lv);
        case (a)
            5'h00:   return {8'h00, m_own, 1'b0};
            5'h04:   return {10'h000, m_div};
            5'h08:   return {8'h00, m_en, m_ie, m_ms, m_tx, m_ak, 3'b000};
            5'h0C:   return {8'h00, lv[4], lv[3], lv[2], m_arb, 1'b0, lv[1], m_irqf, lv[0]};
            5'h10:   return {8'h00, m_data};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string req_of(input logic [4:0] a);
        case (a)
            5'h08:   return "R3";
            5'h0C:   return "R7";
            5'h10:   return "R11";
            default: return "R2";
        endcase
    endfunction

    task automatic step(input logic wr, input logic rd, input logic [4:0] a, input logic [15:0] wd,
                        input logic [2:0] ev, input logic [4:0] lv, input logic rw,
                        input logic [7:0] rb, input string rtag);
        logic [15:0] e_rd;
        logic e_st, e_sp, e_rs, e_ld, e_rr;
        host_wr = wr; host_rd = rd; host_addr = a; host_wdata = wd;
        ev_byte_done = ev[0]; ev_addr_match = ev[1]; ev_arb_lost = ev[2];
        lv_nack = lv[0]; lv_slave_rd = lv[1]; lv_bus_busy = lv[2];
        lv_addressed = lv[3]; lv_xfer_done = lv[4];
        rx_wr = rw; rx_byte = rb;
        e_rd = rd ? rd_val(a, lv) : 16'h0000;
        e_st = 0; e_sp = 0; e_rs = 0;
        if (wr && a == 5'h08) begin
            e_st = wd[7] & wd[5] & ~m_ms;
            e_sp = wd[7] & ~wd[5] & m_ms;
            e_rs = wd[7] & wd[2];
            m_en = wd[7]; m_ie = wd[6]; m_ms = wd[5]; m_tx = wd[4]; m_ak = wd[3];
        end
        if (wr && a == 5'h00) m_own = wd[7:1];
        if (wr && a == 5'h04) m_div = wd[5:0];
        if (wr && a == 5'h0C) begin
            if (!wd[1]) m_irqf = 0;
            if (!wd[4]) m_arb = 0;
        end
        if (|ev) m_irqf = 1;
        if (ev[2]) m_arb = 1;
        e_ld = wr && a == 5'h10;
        if (e_ld) m_data = wd[7:0];
        else if (rw) m_data = rb;
        e_rr = rd && a == 5'h10;
        @(posedge clk);
        @(negedge clk);
        chk(rtag == "" ? req_of(a) : rtag, "host_rdata", host_rdata, e_rd);
        chk("R5", "start_req", start_req, e_st);
        chk("R5", "stop_req", stop_req, e_sp);
        chk("R6", "rstart_req", rstart_req, e_rs);
        chk("R11", "tx_load", tx_load, e_ld);
        chk("R11", "rx_read", rx_read, e_rr);
        chk("R11", "tx_byte", tx_byte, m_data);
        chk("R4", "master_mode", master_mode, m_ms & m_en);
        chk("R4", "tx_mode", tx_mode, m_tx & m_en);
        chk("R4", "ack_off", ack_off, m_ak & m_en);
        chk("R3", "core_en", core_en, m_en);
        chk("R10", "irq", irq, m_irqf & m_ie & m_en);
        chk("R2", "own_addr", own_addr, m_own);
        chk("R2", "clk_code", clk_code, m_div);
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [15:0] wd, input string tag);
        step(1, 0, a, wd, 3'b000, 5'b00000, 0, 8'h00, tag);
    endtask

    task automatic rd_reg(input logic [4:0] a, input logic [4:0] lv, input string tag);
        step(0, 1, a, 16'h0000, 3'b000, lv, 0, 8'h00, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "host_rdata", host_rdata, 0);
        chk("R1", "outputs", {own_addr, clk_code, core_en, ack_off, tx_mode, master_mode,
                              start_req, stop_req, rstart_req, tx_byte, tx_load, rx_read, irq}, 0);
        for (int i = 0; i < 5; i++) rd_reg(5'(i * 4), 5'b00000, "R1");

        // R2 field widths and unmapped offset
        wr_reg(5'h00, 16'hFFFF, "R2");
        rd_reg(5'h00, 5'b00000, "R2");
        wr_reg(5'h04, 16'hFFFF, "R2");
        rd_reg(5'h04, 5'b00000, "R2");
        wr_reg(5'h14, 16'hFFFF, "R2");
        rd_reg(5'h14, 5'b00000, "R2");

        // R4 enable clear: master bit stored but no effect
        wr_reg(5'h08, 16'h007C, "R4");
        rd_reg(5'h08, 5'b00000, "R3");
        // R6 enable now set, master unchanged, repeated start requested
        wr_reg(5'h08, 16'h00FC, "R6");
        // R5 stop then start, then same value again
        wr_reg(5'h08, 16'h0080, "R5");
        wr_reg(5'h08, 16'h00A0, "R5");
        wr_reg(5'h08, 16'h00A0, "R5");

        // R7 live status bits
        rd_reg(5'h0C, 5'b10101, "R7");
        rd_reg(5'h0C, 5'b01010, "R7");

        // R8 events with irq enable off
        wr_reg(5'h08, 16'h0080, "R8");
        step(0, 0, 5'h00, 16'h0, 3'b100, 5'b00000, 0, 8'h00, "R8");
        rd_reg(5'h0C, 5'b00000, "R8");
        wr_reg(5'h08, 16'h00C0, "R10");

        // R9 write 1 has no effect, clear+event same cycle keeps flag, then clear
        wr_reg(5'h0C, 16'hFFFF, "R9");
        rd_reg(5'h0C, 5'b00000, "R9");
        step(1, 0, 5'h0C, 16'h0000, 3'b001, 5'b00000, 0, 8'h00, "R9");
        rd_reg(5'h0C, 5'b00000, "R9");
        wr_reg(5'h0C, 16'h0000, "R9");
        rd_reg(5'h0C, 5'b00000, "R9");

        // R11 data: host write versus receive load in one cycle
        step(1, 0, 5'h10, 16'h12A5, 3'b000, 5'b00000, 1, 8'h3C, "R11");
        rd_reg(5'h10, 5'b00000, "R11");
        step(0, 0, 5'h00, 16'h0, 3'b000, 5'b00000, 1, 8'hC3, "R11");
        rd_reg(5'h10, 5'b00000, "R11");

        // random phase
        for (int n = 0; n < 3000; n++) begin
            int r;
            logic [4:0] a;
            r = int'($urandom_range(0, 5));
            a = (r < 5) ? 5'(r * 4) : 5'($urandom_range(0, 31));
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, 16'($urandom),
                 {($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0)},
                 5'($urandom), ($urandom_range(0, 3) == 0), 8'($urandom), "");
        end

        step(0, 0, 5'h00, 16'h0, 3'b000, 5'b00000, 0, 8'h00, "");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule